// File: doc/BRIEF.md
# I2C Target Front End with Address Match

This block is the bus-facing half of an I2C target. It runs on a fast system clock, at least eight times the SCL rate, and oversamples both bus lines through a synchroniser. It finds START and STOP conditions and shifts in the address byte. It compares that byte with a fixed identity nibble and with strap inputs. On a match it acknowledges, unless a busy input says an internal programming cycle is still running. Holding off that acknowledge lets a host poll for completion by repeating the address until it is acknowledged.

After a write address, each received byte is handed to a command layer as a one-cycle strobe. The command layer's accept level then decides whether the byte is acknowledged. After a read address, the block asks the command layer for a byte and drives it most significant bit first. It then watches the controller's acknowledge: a low asks for another byte, and a high ends the transfer until the next STOP or START. The pad is open-drain. The block only ever pulls SDA low through an output enable and never drives it high.

Top module: `i2c_target_front`

## Requirements
- R1: While and right after synchronous reset, sda_oe, rx_valid and tx_req are 0.
- R2: A falling SDA while SCL is high (START) is honoured in every state. It releases SDA and restarts address reception from bit 7, even in the middle of a byte.
- R3: A rising SDA while SCL is high (STOP) returns the block to idle. Bits clocked after a STOP and before a START draw no acknowledge and give no rx_valid.
- R4: The first byte after START matches when bits 7..4 equal 4'b0101 and bits 3..1 equal strap[2:0]. Bit 0 gives the direction: 0 is write and 1 is read. A match with busy low pulls SDA low for the whole ninth clock.
- R5: On an address mismatch the block gives no acknowledge, no rx_valid and no tx_req until the next START.
- R6: While busy is 1 at the end of the address byte, a matching address is not acknowledged and the transfer is ignored until the next START.
- R7: In write mode each byte is received MSB first. After its eighth rising SCL edge, rx_valid pulses for exactly one system clock with the byte on rx_byte.
- R8: ack_enable is sampled at the falling SCL edge after the eighth bit of a write byte. A 1 gives an acknowledge. A 0 gives none, and later bytes are ignored until START or STOP.
- R9: In read mode tx_req pulses for one cycle after a read address is matched and after each controller acknowledge. tx_byte is taken at the falling SCL edge that ends the ninth clock. Bits go out MSB first: a 0 by pulling SDA low and a 1 by releasing it.
- R10: A high (no acknowledge) from the controller in the ninth clock of a read byte leaves SDA released and stops tx_req until the next START.
- R11: sda_oe changes only while SCL is low, a few system clocks after a falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line as seen at the pad |
| sda_in | input | 1 | SDA line as seen at the pad |
| strap | input | 3 | Board strap bits compared with address bits 3..1 |
| busy | input | 1 | Internal cycle running; suppresses the address acknowledge |
| ack_enable | input | 1 | Command layer accepts the current write byte |
| tx_byte | input | 8 | Byte to send, valid from the cycle after tx_req |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a received write byte |
| tx_req | output | 1 | One-cycle request for the next read byte |

## Verification
A bit counter that is off by one shows at once at the pad. The acknowledge low lands one SCL clock early or late, and a received or sent byte comes out shifted, in the very first byte of a transfer. A wrong transfer state shows as an acknowledge where none is due, or a missing one, within the ninth clock of the byte concerned. It can also show as an rx_valid or tx_req strobe after a mismatch, a busy refusal or a controller refusal. A START or STOP that is not caught leaves the block out of step, so the address of the next transfer gets the wrong acknowledge.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_RD_NEXT
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              rd;
        logic              oe;
        logic              rxv;
        logic              txr;
        logic              scl_p;
        logic              sda_p;
    } tgt_regs_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_q;

    // Idle bus is high, so the chain resets to ones.
    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [3:0] FIXED_ID = 4'b0101,
    parameter int         STRAP_W  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl,
    input  logic               sda,
    input  logic [STRAP_W-1:0] strap,
    input  logic               busy,
    input  logic               ack_enable,
    input  logic [BYTE_W-1:0]  tx_byte,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  rx_byte,
    output logic               rx_valid,
    output logic               tx_req
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    tgt_regs_t q, d;
    logic rise, fall, start_c, stop_c, id_ok;

    always_comb begin
        rise    = scl & ~q.scl_p;
        fall    = ~scl & q.scl_p;
        start_c = q.scl_p & scl & q.sda_p & ~sda;
        stop_c  = q.scl_p & scl & ~q.sda_p & sda;
        id_ok   = (q.sh[BYTE_W-1 -: 4] == FIXED_ID) && (q.sh[STRAP_W:1] == strap);

        d       = q;
        d.rxv   = 1'b0;
        d.txr   = 1'b0;
        d.scl_p = scl;
        d.sda_p = sda;

        if (start_c) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_c) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (rise && q.cnt != FULL) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda};
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall && q.cnt == FULL) begin
                        if (id_ok && !busy) begin
                            d.oe  = 1'b1;
                            d.rd  = q.sh[0];
                            d.txr = q.sh[0];
                            d.st  = ST_ADDR_ACK;
                        end else begin
                            d.st  = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (fall) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.sh = tx_byte;
                            d.oe = ~tx_byte[BYTE_W-1];
                            d.st = ST_RD_DATA;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_WR_DATA;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (rise && q.cnt != FULL) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda};
                        d.cnt = q.cnt + 1'b1;
                        d.rxv = (q.cnt == LAST);
                    end else if (fall && q.cnt == FULL) begin
                        if (ack_enable) begin
                            d.oe = 1'b1;
                            d.st = ST_WR_ACK;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_WR_DATA;
                    end
                end
                ST_RD_DATA: begin
                    if (fall) begin
                        if (q.cnt == LAST) begin
                            d.oe = 1'b0;
                            d.st = ST_RD_ACK;
                        end else begin
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe  = ~q.sh[BYTE_W-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (rise) begin
                        if (!sda) begin
                            d.txr = 1'b1;
                            d.st  = ST_RD_NEXT;
                        end else begin
                            d.st  = ST_IDLE;
                        end
                    end
                end
                ST_RD_NEXT: begin
                    if (fall) begin
                        d.sh  = tx_byte;
                        d.oe  = ~tx_byte[BYTE_W-1];
                        d.cnt = '0;
                        d.st  = ST_RD_DATA;
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe   = q.oe;
    assign rx_byte  = q.sh;
    assign rx_valid = q.rxv;
    assign tx_req   = q.txr;
endmodule

// File: rtl/i2c_target_front.sv
module i2c_target_front
    import i2c_tgt_pkg::*;
#(
    parameter logic [3:0] FIXED_ID    = 4'b0101,
    parameter int         STRAP_W     = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap,
    input  logic               busy,
    input  logic               ack_enable,
    input  logic [BYTE_W-1:0]  tx_byte,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  rx_byte,
    output logic               rx_valid,
    output logic               tx_req
);
    logic [1:0] lines_s;

    i2c_tgt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({scl_in, sda_in}),
        .dout (lines_s)
    );

    i2c_tgt_engine #(.FIXED_ID(FIXED_ID), .STRAP_W(STRAP_W)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .scl        (lines_s[1]),
        .sda        (lines_s[0]),
        .strap      (strap),
        .busy       (busy),
        .ack_enable (ack_enable),
        .tx_byte    (tx_byte),
        .sda_oe     (sda_oe),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .tx_req     (tx_req)
    );
endmodule

// File: rtl/i2c_target_front_chk.sv
module i2c_target_front_chk (
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic sda_oe,
    input logic rx_valid,
    input logic tx_req
);
    // R11
    oe_quiet_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_in);

    // R7
    rx_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R9
    tx_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_req |=> !tx_req);

    // R7
    rx_tx_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && tx_req));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!sda_oe && !rx_valid && !tx_req));
endmodule

bind i2c_target_front i2c_target_front_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_oe   (sda_oe),
    .rx_valid (rx_valid),
    .tx_req   (tx_req)
);

// File: tb/i2c_target_front_test.sv
module i2c_target_front_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_ctl = 1'b1;
    logic       sda_ctl = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       busy = 1'b0;
    logic       ack_en = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic       sda_oe, rx_valid, tx_req;
    logic [7:0] rx_byte;
    wire        sda_line = sda_ctl & ~sda_oe;

    int n_chk = 0, n_bad = 0, unstable = 0, cycles = 0;
    int rx_cnt = 0, txr_cnt = 0;
    logic [7:0] rx_log [0:7];
    logic [7:0] tx_q   [0:7];

    always #5 clk = ~clk;

    i2c_target_front uut (
        .clk(clk), .rst(rst), .scl_in(scl_ctl), .sda_in(sda_line),
        .strap(strap), .busy(busy), .ack_enable(ack_en), .tx_byte(tx_byte),
        .sda_oe(sda_oe), .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_req(tx_req)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_log[rx_cnt % 8] = rx_byte;
            rx_cnt++;
        end
        if (tx_req) begin
            tx_byte = tx_q[txr_cnt % 8];
            txr_cnt++;
        end
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 180000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            report();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic seen);
        logic late;
        scl_ctl = 1'b0; wait_q();
        sda_ctl = b;    wait_q();
        scl_ctl = 1'b1; wait_q();
        seen = sda_line; wait_q();
        late = sda_line;
        if (late !== seen) unstable++;
    endtask

    task automatic bus_start();
        scl_ctl = 1'b0; wait_q();
        sda_ctl = 1'b1; wait_q();
        scl_ctl = 1'b1; wait_q();
        sda_ctl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        scl_ctl = 1'b0; wait_q();
        sda_ctl = 1'b0; wait_q();
        scl_ctl = 1'b1; wait_q();
        sda_ctl = 1'b1; wait_q();
    endtask

    // returns 1 when the target acknowledged
    task automatic put_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i], s);
        send_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic get_byte(input logic more, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, s);
            b[i] = s;
        end
        send_bit(~more, s);
    endtask

    function automatic logic exp_addr_ack(input logic [7:0] a, input logic [2:0] st, input logic bz);
        return (a[7:4] == 4'b0101) && (a[3:1] == st) && !bz;
    endfunction

    logic       ak;
    logic [7:0] got;
    int         rx0, tx0;

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 sda_oe in reset", sda_oe, 1'b0);
        chk("R1 rx_valid in reset", rx_valid, 1'b0);
        chk("R1 tx_req in reset", tx_req, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset", {sda_oe, rx_valid, tx_req}, 3'b000);
        wait_q();

        // R4 R7 R8: matched write of two bytes
        rx0 = rx_cnt;
        bus_start();
        put_byte(8'h5A, ak); chk("R4 write address ack", ak, 1'b1);
        put_byte(8'hC3, ak); chk("R8 byte1 ack", ak, 1'b1);
        chk("R7 byte1 value", rx_log[rx0 % 8], 8'hC3);
        put_byte(8'h3C, ak); chk("R8 byte2 ack", ak, 1'b1);
        chk("R7 byte2 value", rx_log[(rx0 + 1) % 8], 8'h3C);
        chk("R7 strobe count", rx_cnt - rx0, 2);
        bus_stop();

        // R5: wrong fixed nibble, then wrong strap
        rx0 = rx_cnt; tx0 = txr_cnt;
        bus_start();
        put_byte(8'h7A, ak); chk("R5 nibble mismatch nack", ak, 1'b0);
        put_byte(8'h11, ak); chk("R5 data after mismatch nack", ak, 1'b0);
        bus_stop();
        bus_start();
        put_byte(8'h59, ak); chk("R5 strap mismatch nack", ak, 1'b0);
        get_byte(1'b0, got); chk("R5 no drive after mismatch", got, 8'hFF);
        bus_stop();
        chk("R5 no strobes", {rx_cnt - rx0, txr_cnt - tx0}, 64'd0);

        // R6: busy refuses own address (ack polling)
        busy = 1'b1;
        bus_start();
        put_byte(8'h5A, ak); chk("R6 busy nack", ak, 1'b0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        put_byte(8'h5A, ak); chk("R6 poll ack after busy", ak, 1'b1);
        bus_stop();

        // R8: refused byte then ignored
        rx0 = rx_cnt;
        bus_start();
        put_byte(8'h5A, ak);
        ack_en = 1'b0;
        put_byte(8'h96, ak); chk("R8 refused byte nack", ak, 1'b0);
        ack_en = 1'b1;
        put_byte(8'h69, ak); chk("R8 later byte ignored", ak, 1'b0);
        chk("R8 one strobe only", rx_cnt - rx0, 1);
        bus_stop();

        // R9 R10: read two bytes, controller refuses the second
        tx0 = txr_cnt;
        tx_q[tx0 % 8] = 8'hA5; tx_q[(tx0 + 1) % 8] = 8'h0F;
        bus_start();
        put_byte(8'h5B, ak); chk("R4 read address ack", ak, 1'b1);
        get_byte(1'b1, got); chk("R9 read byte1", got, 8'hA5);
        get_byte(1'b0, got); chk("R9 read byte2", got, 8'h0F);
        get_byte(1'b0, got); chk("R10 released after nack", got, 8'hFF);
        chk("R10 request count", txr_cnt - tx0, 2);
        bus_stop();

        // R2: START in the middle of an address byte
        bus_start();
        for (int i = 0; i < 3; i++) send_bit(1'b0, ak);
        bus_start();
        put_byte(8'h5A, ak); chk("R2 restart mid byte ack", ak, 1'b1);
        bus_stop();

        // R3: bits after STOP with no START
        rx0 = rx_cnt;
        put_byte(8'h5A, ak); chk("R3 no ack without start", ak, 1'b0);
        put_byte(8'h22, ak); chk("R3 no ack data", ak, 1'b0);
        chk("R3 no strobe", rx_cnt - rx0, 0);

        // random transactions
        for (int t = 0; t < 40; t++) begin
            logic [7:0] a;
            logic       alive, e;
            int         nb;
            strap = 3'($urandom);
            busy  = ($urandom % 5) == 0;
            if (($urandom % 2) == 0) a = {4'b0101, strap, 1'($urandom)};
            else                     a = 8'($urandom);
            nb = 1 + ($urandom % 3);
            rx0 = rx_cnt; tx0 = txr_cnt;
            for (int k = 0; k < 4; k++) tx_q[(tx0 + k) % 8] = 8'($urandom);
            bus_start();
            put_byte(a, ak);
            alive = exp_addr_ack(a, strap, busy);
            chk("R4 R5 R6 random address", ak, alive);
            busy = 1'b0;
            if (!a[0]) begin
                int nexp;
                nexp = 0;
                for (int k = 0; k < nb; k++) begin
                    logic [7:0] v;
                    v = 8'($urandom);
                    ack_en = ($urandom % 5) != 0;
                    e = alive && ack_en;
                    put_byte(v, ak);
                    chk("R8 random write ack", ak, e);
                    if (alive) begin
                        chk("R7 random write value", rx_log[(rx0 + nexp) % 8], v);
                        nexp++;
                    end
                    alive = e;
                end
                chk("R7 random strobe count", rx_cnt - rx0, nexp);
                ack_en = 1'b1;
            end else begin
                for (int k = 0; k < nb; k++) begin
                    get_byte(k != nb - 1, got);
                    chk("R9 random read", got, alive ? tx_q[(tx0 + k) % 8] : 8'hFF);
                end
                chk("R10 random request count", txr_cnt - tx0, alive ? nb : 0);
            end
            bus_stop();
        end

        chk("R11 SDA stable while SCL high", unstable, 0);
        report();
        $finish;
    end
endmodule